// File: doc/BRIEF.md
# Sampled Sensor Debounce with Change Interrupt

This block sits between eight raw comparator outputs and the register that a serial host reads. It turns the raw levels into stable per-channel states. When a stable state changes, it pulls an active-low interrupt line for a fixed number of clock cycles, so the host does not have to poll.

The `dbnc_en` input selects one of two paths:

- **Debounce on (`dbnc_en` high):** a free-running prescaler issues a sample tick every `SAMPLE_CYC` system clock cycles. A channel's stable bit takes a new value only when two consecutive tick samples agree on it. The default period is 60 ms at 100 MHz.
- **Debounce off (`dbnc_en` low):** the synchronised raw level passes straight through. The added delay is three clock cycles.

The interrupt is open-drain. It is modelled as a single enable, `irq_pull`: 1 means drive the line low and 0 means release it. A change that arrives while a pulse is active reloads the pulse to its full width.

Top module: `sense_debounce_irq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `stable_out` is all zeros and `irq_pull` is 0. Reset also clears the sample history.
- R2: With `dbnc_en` low, a level applied to `raw_in` before clock edge k appears on `stable_out` right after edge k+2. It is not visible after edge k+1.
- R3: With `dbnc_en` high, a bit of `stable_out` changes only on a sample tick, and only when that tick's sample matches the previous tick's sample.
- R4: With `dbnc_en` high, a lasting change of `raw_in` reaches `stable_out` no sooner than `SAMPLE_CYC`+3 and no later than 2*`SAMPLE_CYC`+2 clock edges after it is applied.
- R5: With `dbnc_en` high, a raw pulse shorter than `SAMPLE_CYC` cycles leaves `stable_out` unchanged and never asserts `irq_pull`.
- R6: On the edge where any bit of `stable_out` changes, `irq_pull` becomes 1 and stays 1 for exactly `PULSE_CYC` cycles when no further change follows.
- R7: A change of `stable_out` while `irq_pull` is 1 restarts the pulse at full width. The line stays asserted without a gap until `PULSE_CYC` cycles after the last change.
- R8: Channels are debounced independently. A settled change on one bit updates that bit while a glitching bit in the same vector keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbnc_en | input | 1 | 1 selects tick-sampled debounce; 0 selects direct pass-through |
| raw_in | input | N_CH | Raw comparator levels, one bit per channel, asynchronous |
| stable_out | output | N_CH | Debounced channel states for the data register |
| irq_pull | output | 1 | 1 = drive the open-drain interrupt line low, 0 = release |

## Verification
The most likely internal fault is a corrupted sample history or an off-by-one in the prescaler. It shows at the ports as a stable bit that moves after a single sample, or that settles outside the window one to two sample periods after the input change. A glitch test and an edge-count latency test catch that within three periods.

A wrong pulse counter shows up on the first change as an interrupt that is too short, too long, or broken by a gap when a second change lands inside it. The pass-through path is checked on the exact edge where its three-register delay ends.

// File: rtl/sense_debounce_irq.sv
module sense_debounce_irq #(
  parameter int N_CH       = 8,
  parameter int SAMPLE_CYC = 6000000,
  parameter int PULSE_CYC  = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbnc_en,
  input  logic [N_CH-1:0] raw_in,
  output logic [N_CH-1:0] stable_out,
  output logic            irq_pull
);
  localparam int TW = $clog2(SAMPLE_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [N_CH-1:0] sync1, sync2, last_smp, agree, stable_nxt;
  logic [TW-1:0]   tick_cnt;
  logic [PW-1:0]   pulse_cnt;
  logic            tick, changed;

  assign tick    = (tick_cnt == TW'(SAMPLE_CYC - 1));
  assign agree   = ~(sync2 ^ last_smp);
  assign stable_nxt = !dbnc_en ? sync2 :
                      tick     ? ((stable_out & ~agree) | (sync2 & agree)) :
                                 stable_out;
  assign changed  = |(stable_nxt ^ stable_out);
  assign irq_pull = (pulse_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= '0;
      sync2      <= '0;
      last_smp   <= '0;
      stable_out <= '0;
      tick_cnt   <= '0;
      pulse_cnt  <= '0;
    end else begin
      sync1      <= raw_in;
      sync2      <= sync1;
      stable_out <= stable_nxt;
      tick_cnt   <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)
        last_smp <= sync2;
      if (changed)
        pulse_cnt <= PW'(PULSE_CYC);
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  // R1
  always_ff @(posedge clk)
    if (!rst_n) reset_release_chk: assert (!irq_pull && stable_out == '0);

  // R6
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_out != $past(stable_out)) |-> irq_pull);

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> (stable_out != $past(stable_out)));

  // R3
  dbnc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stable_out != $past(stable_out)) && $past(dbnc_en)) |-> $past(tick));

  // R3
  dbnc_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stable_out != $past(stable_out)) && $past(dbnc_en))
      |-> (((stable_out ^ $past(stable_out)) & ($past(last_smp) ^ stable_out)) == '0));
endmodule

// File: tb/sense_debounce_irq_tb.sv
module sense_debounce_irq_tb;
  localparam int N  = 8;
  localparam int SP = 10;
  localparam int PL = 4;

  logic clk = 0, rst_n = 0, dbnc_en = 0;
  logic [N-1:0] raw_in = '0;
  logic [N-1:0] stable_out;
  logic irq_pull;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sense_debounce_irq #(.N_CH(N), .SAMPLE_CYC(SP), .PULSE_CYC(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbnc_en(dbnc_en), .raw_in(raw_in),
    .stable_out(stable_out), .irq_pull(irq_pull));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset;
    step(3);
    check("R1 state in reset", stable_out, 0);
    check("R1 irq in reset", irq_pull, 0);
    @(negedge clk); rst_n = 1;
    step(1);
    check("R1 state after release", stable_out, 0);
    check("R1 irq after release", irq_pull, 0);
  endtask

  task automatic t_bypass;
    dbnc_en = 0;
    @(negedge clk); raw_in = 8'hA5;
    step(2);
    check("R2 not yet visible", stable_out, 0);
    step(1);
    check("R2 pass-through", stable_out, 8'hA5);
    check("R6 irq starts", irq_pull, 1);
    step(PL - 1);
    check("R6 irq still held", irq_pull, 1);
    step(1);
    check("R6 irq released after width", irq_pull, 0);
  endtask

  task automatic t_restart;
    int highs = 0;
    int falls = 0;
    logic prev = 0;
    dbnc_en = 0;
    @(negedge clk); raw_in = 8'h0F;
    step(3);
    check("R7 first pulse", irq_pull, 1);
    prev = 1; highs = 1;
    @(negedge clk); raw_in = 8'hF0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (irq_pull) highs++;
      if (prev && !irq_pull) falls++;
      prev = irq_pull;
    end
    check("R7 extended width", highs, PL + 3);
    check("R7 no gap", falls, 1);
    check("R7 final state", stable_out, 8'hF0);
  endtask

  task automatic t_debounce;
    int n = 0;
    dbnc_en = 1;
    step(3 * SP);
    check("R3 settled before test", stable_out, 8'hF0);
    @(negedge clk); raw_in = 8'h3C;
    step(3);
    n = 3;
    check("R3 no update without samples", stable_out, 8'hF0);
    while (stable_out == 8'hF0 && n < 4 * SP) begin
      step(1); n++;
    end
    check("R4 value after debounce", stable_out, 8'h3C);
    check("R4 latency lower bound", (n >= SP + 3), 1);
    check("R4 latency upper bound", (n <= 2 * SP + 2), 1);
    check("R6 irq with debounced change", irq_pull, 1);
  endtask

  task automatic t_glitch;
    int seen = 0;
    dbnc_en = 1;
    step(3 * SP);
    @(negedge clk); raw_in = 8'hC3;
    step(3);
    @(negedge clk); raw_in = 8'h3C;
    for (int i = 0; i < 5 * SP; i++) begin
      step(1);
      if (irq_pull) seen++;
    end
    check("R5 glitch ignored", stable_out, 8'h3C);
    check("R5 no irq on glitch", seen, 0);
  endtask

  task automatic t_channels;
    dbnc_en = 1;
    @(negedge clk); raw_in = 8'h3D;
    step(2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); raw_in = raw_in ^ 8'h02;
      step(SP / 2 - 1);
    end
    step(3 * SP);
    check("R8 independent channels", stable_out, 8'h3D);
    @(negedge clk); raw_in = 8'h3D;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_restart();
    t_debounce();
    t_glitch();
    t_channels();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule